// File: doc/BRIEF.md
# Modem Control Line Port

This block gives a serial communications block register access to its four modem handshake lines. Two register bits drive the RTS and DTR pins. In every mode except the default one, the drive is active-low. In the default mode both pins are held in their inactive (high) state. The DSR and RI pin levels can be read back live at any time. The block does not latch those levels.

A separate status register serves interrupt-driven software. It holds synchronised copies of DSR and RI, plus one sticky change flag per line. A flag is set on either edge of its line and is cleared by writing 1 to it. The interrupt request is the OR of the flags whose enable bits are set.

One more option routes the RI pin directly onto a general-purpose output pin. This path has no clocking and works in every mode.

Top module: `mcl_port`

## Requirements
- R1: After reset, all register bits are 0, `rts_n` and `dtr_n` are 1, `gout` is 0 and `irq` is 0.
- R2: When `mode_sel` is 2'b00, `rts_n` and `dtr_n` are both 1, whatever the output register holds.
- R3: When `mode_sel` is not 2'b00, `rts_n` equals the inverse of output register (address 0) bit 3, and `dtr_n` equals the inverse of bit 2.
- R4: Output register bits [3:0] read back as written. Its bits [7:4] read as 0.
- R5: Input register (address 1) bit 1 reads the current `dsr` pin and bit 0 reads the current `ri` pin, in the same cycle, with no clock edge needed.
- R6: While input register bit 7 (read/write) is 1, `gout` follows `ri` combinationally in every mode. While bit 7 is 0, `gout` is 0.
- R7: Status register (address 2) bit 1 shows `dsr` and bit 0 shows `ri`, each after a two-flop synchroniser.
- R8: Either edge on `ri` sets status bit 4, and either edge on `dsr` sets status bit 5. The flag is visible by the third rising clock edge after the pin changes, and it stays set.
- R9: Writing 1 to status bit 4 or 5 clears that flag. Writing 0 leaves it unchanged.
- R10: `irq` is 1 exactly while some flag is set and its enable is set. Enable register (address 3) bit 0 enables the RI flag and bit 1 enables the DSR flag. A disabled flag never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Communications mode select, 00 = default |
| bus_addr | input | 2 | Register address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| dsr | input | 1 | Data-set-ready pin |
| ri | input | 1 | Ring indicator pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| gout | output | 1 | General-purpose output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench sets RTS and DTR bits and then switches modes. A design that inverted the polarity, or that drove the pins in the default mode, shows the wrong level.

It changes the pins and reads the input register before any clock edge. A design that latched the levels would return stale values.

It makes both rising and falling edges on each line. A design that detected only one direction, or that swapped the flag positions, is caught.

It writes 0 and then 1 to the flags, and it toggles the enables. A design that cleared on any write, or that ignored the enables, shows a wrong flag or a wrong `irq` level.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NUM_IN = 2;   // index 0 = RI, 1 = DSR

  localparam logic [ADDR_W-1:0] A_OUT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_IN   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd3;

  localparam int B_RTS   = 3;
  localparam int B_DTR   = 2;
  localparam int B_ROUTE = 7;
  localparam int B_FLAG0 = 4;

  typedef enum logic [1:0] {
    MODE_DEFAULT = 2'b00,
    MODE_ALT1    = 2'b01,
    MODE_ALT2    = 2'b10,
    MODE_ALT3    = 2'b11
  } mode_e;
endpackage

// File: rtl/mcl_sync.sv
module mcl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mcl_chg_detect.sv
module mcl_chg_detect #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] flag_q, flag_d;
  logic [WIDTH-1:0] hit;

  assign hit = lvl ^ prev_q;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_flag
      always_comb begin
        // a new edge takes priority over a clear in the same cycle
        if (hit[i])      flag_d[i] = 1'b1;
        else if (clr[i]) flag_d[i] = 1'b0;
        else             flag_d[i] = flag_q[i];
      end
    end
  endgenerate

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/mcl_outdrv.sv
module mcl_outdrv (
  input  logic [1:0] mode_sel,
  input  logic       rts_bit,
  input  logic       dtr_bit,
  input  logic       route_en,
  input  logic       ri_pin,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       gout
);
  import mcl_pkg::*;
  logic drive_en;

  assign drive_en = (mode_e'(mode_sel) != MODE_DEFAULT);

  always_comb begin
    if (drive_en) begin
      rts_n = ~rts_bit;
      dtr_n = ~dtr_bit;
    end else begin
      rts_n = 1'b1;
      dtr_n = 1'b1;
    end
    gout = route_en & ri_pin;
  end
endmodule

// File: rtl/mcl_port.sv
module mcl_port
  import mcl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dsr,
  input  logic              ri,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              gout,
  output logic              irq
);
  localparam int OUT_BITS = 4;

  logic [OUT_BITS-1:0] out_q, out_d;
  logic                route_q, route_d;
  logic [NUM_IN-1:0]   ien_q, ien_d;
  logic [NUM_IN-1:0]   pins;
  logic [NUM_IN-1:0]   lvl_sync;
  logic [NUM_IN-1:0]   chg_flags;
  logic [NUM_IN-1:0]   clr_mask;
  logic                wr_out, wr_in, wr_stat, wr_ien;
  logic                unused_wbit;

  assign pins = {dsr, ri};

  assign wr_out  = bus_wen && (bus_addr == A_OUT);
  assign wr_in   = bus_wen && (bus_addr == A_IN);
  assign wr_stat = bus_wen && (bus_addr == A_STAT);
  assign wr_ien  = bus_wen && (bus_addr == A_IEN);

  assign unused_wbit = bus_wdata[6];

  always_comb begin
    out_d   = out_q;
    route_d = route_q;
    ien_d   = ien_q;
    if (wr_out) out_d   = bus_wdata[OUT_BITS-1:0];
    if (wr_in)  route_d = bus_wdata[B_ROUTE];
    if (wr_ien) ien_d   = bus_wdata[NUM_IN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      route_q <= 1'b0;
      ien_q   <= '0;
    end else begin
      out_q   <= out_d;
      route_q <= route_d;
      ien_q   <= ien_d;
    end
  end

  assign clr_mask = wr_stat ? bus_wdata[B_FLAG0 +: NUM_IN] : '0;

  mcl_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(lvl_sync)
  );

  mcl_chg_detect #(.WIDTH(NUM_IN)) chg_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .clr(clr_mask), .flags(chg_flags)
  );

  mcl_outdrv drv_i (
    .mode_sel(mode_sel), .rts_bit(out_q[B_RTS]), .dtr_bit(out_q[B_DTR]),
    .route_en(route_q), .ri_pin(ri),
    .rts_n(rts_n), .dtr_n(dtr_n), .gout(gout)
  );

  assign irq = |(chg_flags & ien_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_OUT:  bus_rdata[OUT_BITS-1:0] = out_q;
      A_IN: begin
        bus_rdata[NUM_IN-1:0] = pins;
        bus_rdata[B_ROUTE]    = route_q;
      end
      A_STAT: begin
        bus_rdata[NUM_IN-1:0]       = lvl_sync;
        bus_rdata[B_FLAG0 +: NUM_IN] = chg_flags;
      end
      A_IEN:  bus_rdata[NUM_IN-1:0] = ien_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcl_port_chk.sv
module mcl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [1:0] bus_addr,
  input logic       bus_wen,
  input logic [7:0] bus_wdata,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       gout,
  input logic       route_en,
  input logic [1:0] lvl_sync,
  input logic [1:0] flags,
  input logic       irq
);
  logic stat_wr, cfg_wr;
  assign stat_wr = bus_wen && (bus_addr == 2'd2);
  assign cfg_wr  = bus_wen && (bus_addr == 2'd2 || bus_addr == 2'd3);

  assert_default_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (rts_n && dtr_n));

  assert_gout_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en |-> !gout);

  assert_edge_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sync != $past(lvl_sync)) |=> (flags == 2'b11 || flags != 2'b00));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(stat_wr && bus_wdata[4])) |=> flags[0]);

  assert_flag1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(stat_wr && bus_wdata[5])) |=> flags[1]);

  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_wr) |=> irq);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 2'b00));
endmodule

bind mcl_port mcl_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bus_addr(bus_addr),
  .bus_wen(bus_wen), .bus_wdata(bus_wdata), .rts_n(rts_n), .dtr_n(dtr_n),
  .gout(gout), .route_en(route_q), .lvl_sync(lvl_sync), .flags(chg_flags),
  .irq(irq)
);

// File: tb/mcl_port_tb_top.sv
module mcl_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic [1:0] bus_addr;
  logic       bus_wen;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       dsr, ri;
  logic       rts_n, dtr_n, gout, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcl_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dsr(dsr), .ri(ri), .rts_n(rts_n), .dtr_n(dtr_n), .gout(gout), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rts_n", {7'd0, rts_n}, 8'h01);
    check("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    check("R1 gout", {7'd0, gout}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0, v); check("R1 out reg", v, 8'h00);
    rd(2'd2, v); check("R1 stat reg", v, 8'h00);
    rd(2'd3, v); check("R1 ien reg", v, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] v;
    wr(2'd0, 8'hFC);
    mode_sel = 2'b00; #0.5;
    check("R2 rts_n idle", {7'd0, rts_n}, 8'h01);
    check("R2 dtr_n idle", {7'd0, dtr_n}, 8'h01);
    rd(2'd0, v); check("R4 readback", v, 8'h0C);
    for (int m = 1; m < 4; m++) begin
      mode_sel = 2'(m);
      wr(2'd0, 8'h08); #0.5;
      check("R3 rts_n on", {7'd0, rts_n}, 8'h00);
      check("R3 dtr_n off", {7'd0, dtr_n}, 8'h01);
      wr(2'd0, 8'h04); #0.5;
      check("R3 rts_n off", {7'd0, rts_n}, 8'h01);
      check("R3 dtr_n on", {7'd0, dtr_n}, 8'h00);
    end
    wr(2'd0, 8'h05);
    rd(2'd0, v); check("R4 readback2", v, 8'h05);
    mode_sel = 2'b00; #0.5;
    check("R2 back idle", {6'd0, rts_n, dtr_n}, 8'h03);
  endtask

  task automatic t_live();
    logic [7:0] v;
    @(negedge clk);
    dsr = 1'b1; ri = 1'b0;
    rd(2'd1, v); check("R5 dsr live", v, 8'h02);
    dsr = 1'b0; ri = 1'b1;
    rd(2'd1, v); check("R5 ri live", v, 8'h01);
    ri = 1'b0;
    rd(2'd1, v); check("R5 no latch", v, 8'h00);
    settle(5);
    wr(2'd2, 8'h30);
  endtask

  task automatic t_gout();
    logic [7:0] v;
    ri = 1'b1; #0.5;
    check("R6 gout parked", {7'd0, gout}, 8'h00);
    wr(2'd1, 8'h80);
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      ri = 1'b1; #0.5;
      check("R6 gout high", {7'd0, gout}, 8'h01);
      ri = 1'b0; #0.5;
      check("R6 gout low", {7'd0, gout}, 8'h00);
    end
    rd(2'd1, v); check("R6 route bit", v, 8'h80);
    wr(2'd1, 8'h00);
    ri = 1'b1; #0.5;
    check("R6 gout off again", {7'd0, gout}, 8'h00);
    ri = 1'b0;
    settle(5);
    wr(2'd2, 8'h30);
    mode_sel = 2'b00;
  endtask

  task automatic t_edges();
    logic [7:0] v;
    @(negedge clk);
    ri = 1'b1;
    settle(1);
    rd(2'd2, v); check("R7 not yet synced", v, 8'h00);
    settle(2);
    rd(2'd2, v); check("R8 ri rise flag", v, 8'h11);
    wr(2'd2, 8'h10);
    rd(2'd2, v); check("R9 ri cleared", v, 8'h01);
    dsr = 1'b1;
    settle(3);
    rd(2'd2, v); check("R8 dsr rise flag", v, 8'h23);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R9 write 0 keeps", v, 8'h23);
    ri = 1'b0; dsr = 1'b0;
    settle(3);
    rd(2'd2, v); check("R8 both fall", v, 8'h30);
    wr(2'd2, 8'h20);
    rd(2'd2, v); check("R9 dsr cleared only", v, 8'h10);
    settle(4);
    rd(2'd2, v); check("R8 sticky", v, 8'h10);
    wr(2'd2, 8'h10);
    rd(2'd2, v); check("R9 all clear", v, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk);
    ri = 1'b1;
    settle(4);
    check("R10 disabled no irq", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h02);
    check("R10 wrong enable", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h01);
    check("R10 enabled irq", {7'd0, irq}, 8'h01);
    dsr = 1'b1;
    settle(4);
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h10);
    check("R10 irq held by dsr", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h20);
    check("R10 irq drops", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; bus_addr = 2'd0; bus_wen = 1'b0;
    bus_wdata = 8'h00; dsr = 1'b0; ri = 1'b0;
    settle(3);
    t_reset();
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_outputs();
    t_live();
    t_gout();
    t_edges();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule